// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from reset to a ready state and then hands the command bus to the normal read/write path. It drives the chip-select, row strobe, column strobe, write-enable, bank and address pins with a fixed bring-up sequence:

- a programmable power-up wait filled with NOPs;
- one precharge-all-banks command, followed by a precharge recovery wait;
- a programmable number of auto refreshes, eight by default, each followed by a refresh recovery wait;
- a mode-register write, followed by its own recovery wait.

When the last wait ends, the block raises its init-done flag and its refresh-enable flag, and it starts a periodic refresh-request timer.

The mode word, the mode bank bits, the refresh prescaler and the refresh period arrive on configuration inputs. They are captured once, in the first clock after reset is released, before any command is issued. Each command in the sequence takes exactly one clock. Every other cycle carries a NOP.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is low and in the first clock after its release, the pins carry NOP, and `init_done`, `ref_en` and `ref_req` are 0.
- R2: The mode word, mode bank, prescaler and period are sampled in the first clock after reset is released. Changes to these inputs after that clock have no effect on the MRS address/bank or on the refresh interval until the next reset.
- R3: Exactly WAIT_CYC NOP cycles come before the precharge.
- R4: The precharge-all is issued once, for one cycle. It is encoded {cs_n,ras_n,cas_n,we_n}=0010, with `sd_addr` bit 10 set, every other address bit 0 and bank 0. It is followed by T_RP NOP cycles.
- R5: Exactly N_REFRESH auto refreshes follow, each encoded 0001 for one cycle with address and bank 0, and each followed by T_RFC NOP cycles.
- R6: A mode-register set is then issued for one cycle, encoded 0000, with `sd_addr` equal to the captured mode word and `sd_ba` equal to the captured mode bank. It is followed by T_MRD NOP cycles.
- R7: `init_done` and `ref_en` are 0 throughout the sequence. Both rise in the cycle right after the last mode-set recovery NOP, and both stay 1 until reset.
- R8: Every cycle that is not a command carries NOP, encoded 0111, with address and bank 0. This includes every cycle after `init_done` rises.
- R9: `ref_req` is 0 while `ref_en` is 0. Once `ref_en` rises, `ref_req` is 1 in every cycle whose count k since `init_done` rose (the first cycle with `init_done` high is k=0) is a non-zero multiple of (prescale+1)*period, and it is 0 in all other cycles.
- R10: A synchronous reset at any point, including mid-sequence, returns the block to the R1 state. The whole sequence then restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode_word | input | ADDR_W | Mode word placed on the address pins by the mode set |
| cfg_mode_bank | input | BANK_W | Bank bits placed on the bank pins by the mode set |
| cfg_ref_prescale | input | PRE_W | Refresh prescaler; divides the clock by value+1 |
| cfg_ref_period | input | PER_W | Refresh period in prescaled ticks (must be at least 1) |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins |
| sd_ba | output | BANK_W | Bank pins |
| init_done | output | 1 | Bring-up finished; the bus belongs to the normal path |
| ref_en | output | 1 | Periodic refresh enabled |
| ref_req | output | 1 | One-cycle refresh request from the refresh timer |

## Verification
The bench compares the command pins, address and bank against the expected trace in every cycle. A wait that is off by one, or a refresh count of seven or nine, therefore shows up as a command landing in the wrong cycle. It changes the configuration inputs right after the capture clock. A design that keeps sampling them would put the wrong mode word on the bus and refresh at the wrong rate. It checks the refresh requests against the exact interval counted from the rise of `init_done`, which catches a timer that starts early or divides by the prescale value rather than prescale+1. It also resets the block mid-sequence and checks that the power-up wait is replayed in full, catching a design that keeps stale counter or refresh-count state.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM bring-up sequencer.
// Assumes: commands are encoded as {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_LOAD,   // capture configuration
        ST_PWR,    // power-up NOP wait
        ST_PRE,    // precharge-all command
        ST_TRP,    // precharge recovery
        ST_REF,    // auto refresh command
        ST_TRFC,   // refresh recovery
        ST_MRS,    // mode-register set
        ST_TMRD,   // mode-set recovery
        ST_RUN     // normal operation
    } init_state_e;

    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

    // Largest of four wait lengths, used to size the shared wait counter.
    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sinit_wait_cnt.sv
// Down counter shared by every wait phase of the sequencer.
// Does: loads a start value and counts down to zero, then holds.
// Assumes: the caller loads (length-1), so a phase lasts `length` cycles.
module sinit_wait_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sinit_fsm.sv
// Sequencer state machine: power-up wait, precharge-all, N refreshes,
// mode set, each followed by its recovery wait, then run.
// Assumes: every wait length parameter is at least 1.
module sinit_fsm
    import sdram_init_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int WAIT_CYC  = 16,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 9,
    parameter int T_MRD     = 2,
    parameter int N_REFRESH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expired,
    output init_state_e      state,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam int REF_W = $clog2(N_REFRESH + 1);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REFRESH);

    init_state_e      nxt;
    logic [REF_W-1:0] ref_cnt;
    logic             ref_inc;

    // Next-state and wait-counter load decision.
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        ref_inc  = 1'b0;
        case (state)
            ST_LOAD: begin
                nxt = ST_PWR; load = 1'b1; load_val = CNT_W'(WAIT_CYC - 1);
            end
            ST_PWR:  if (expired) nxt = ST_PRE;
            ST_PRE: begin
                nxt = ST_TRP; load = 1'b1; load_val = CNT_W'(T_RP - 1);
            end
            ST_TRP:  if (expired) nxt = ST_REF;
            ST_REF: begin
                nxt = ST_TRFC; load = 1'b1; load_val = CNT_W'(T_RFC - 1);
                ref_inc = 1'b1;
            end
            ST_TRFC: if (expired) nxt = (ref_cnt == REF_LAST) ? ST_MRS : ST_REF;
            ST_MRS: begin
                nxt = ST_TMRD; load = 1'b1; load_val = CNT_W'(T_MRD - 1);
            end
            ST_TMRD: if (expired) nxt = ST_RUN;
            ST_RUN:  nxt = ST_RUN;
            default: nxt = ST_LOAD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= nxt;
    end

    // Count refreshes issued since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       ref_cnt <= '0;
        else if (ref_inc) ref_cnt <= ref_cnt + 1'b1;
    end
endmodule

// File: rtl/sinit_cmd_enc.sv
// Maps the sequencer state to SDRAM command pins, address and bank.
// Assumes: ADDR_W >= 11, so that address bit 10 exists for precharge-all.
module sinit_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input  init_state_e       state,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic [BANK_W-1:0] mode_bank,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

    // One command per state; NOP everywhere else.
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = CMD_NOP;
        addr = '0;
        ba   = '0;
        case (state)
            ST_PRE: begin
                {cs_n, ras_n, cas_n, we_n} = CMD_PRE;
                addr = ALL_BANKS;
            end
            ST_REF: {cs_n, ras_n, cas_n, we_n} = CMD_REF;
            ST_MRS: begin
                {cs_n, ras_n, cas_n, we_n} = CMD_MRS;
                addr = mode_word;
                ba   = mode_bank;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sinit_refresh_timer.sv
// Periodic refresh-request timer: a prescaler (divide by prescale+1)
// feeding a period counter; pulses req once per (prescale+1)*period clocks.
// Assumes: period >= 1; counting starts on the first clock with enable high.
module sinit_refresh_timer #(
    parameter int PRE_W = 8,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] prescale,
    input  logic [PER_W-1:0] period,
    output logic             req
);
    logic [PRE_W-1:0] pc;
    logic [PER_W-1:0] rc;

    // Prescaler and period counters with a registered request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pc  <= '0;
            rc  <= '0;
            req <= 1'b0;
        end else if (pc == prescale) begin
            pc <= '0;
            if (rc == period - 1'b1) begin
                rc  <= '0;
                req <= 1'b1;
            end else begin
                rc  <= rc + 1'b1;
                req <= 1'b0;
            end
        end else begin
            pc  <= pc + 1'b1;
            req <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_boot_seq.sv
// SDRAM power-up initialization sequencer (top).
// Does: captures the configuration, then drives the power-up wait,
// precharge-all, refreshes and mode set, then flags done and runs
// the refresh timer.
// Assumes: synchronous active-low reset; all wait lengths >= 1; ADDR_W >= 11.
module sdram_boot_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BANK_W    = 2,
    parameter int PRE_W     = 8,
    parameter int PER_W     = 16,
    parameter int WAIT_CYC  = 10000,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 9,
    parameter int T_MRD     = 2,
    parameter int N_REFRESH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_mode_word,
    input  logic [BANK_W-1:0] cfg_mode_bank,
    input  logic [PRE_W-1:0]  cfg_ref_prescale,
    input  logic [PER_W-1:0]  cfg_ref_period,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic              init_done,
    output logic              ref_en,
    output logic              ref_req
);
    localparam int MAX_WAIT = max_of4(WAIT_CYC, T_RP, T_RFC, T_MRD);
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    init_state_e       state;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_expired;
    logic [ADDR_W-1:0] mode_q;
    logic [BANK_W-1:0] bank_q;
    logic [PRE_W-1:0]  pre_q;
    logic [PER_W-1:0]  per_q;

    // Capture the configuration once, before any command is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            bank_q <= '0;
            pre_q  <= '0;
            per_q  <= '0;
        end else if (state == ST_LOAD) begin
            mode_q <= cfg_mode_word;
            bank_q <= cfg_mode_bank;
            pre_q  <= cfg_ref_prescale;
            per_q  <= cfg_ref_period;
        end
    end

    sinit_fsm #(
        .CNT_W(CNT_W), .WAIT_CYC(WAIT_CYC), .T_RP(T_RP),
        .T_RFC(T_RFC), .T_MRD(T_MRD), .N_REFRESH(N_REFRESH)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .expired(cnt_expired),
        .state(state), .load(cnt_load), .load_val(cnt_val)
    );

    sinit_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(cnt_load),
        .load_val(cnt_val), .expired(cnt_expired)
    );

    sinit_cmd_enc #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_enc (
        .state(state), .mode_word(mode_q), .mode_bank(bank_q),
        .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
        .addr(sd_addr), .ba(sd_ba)
    );

    assign init_done = (state == ST_RUN);
    assign ref_en    = (state == ST_RUN);

    sinit_refresh_timer #(.PRE_W(PRE_W), .PER_W(PER_W)) u_rtmr (
        .clk(clk), .rst_n(rst_n), .enable(ref_en),
        .prescale(pre_q), .period(per_q), .req(ref_req)
    );
endmodule

// File: rtl/sdram_boot_seq_chk.sv
// Checker for sdram_boot_seq, attached by bind. Watches only the ports.
module sdram_boot_seq_chk #(
    parameter int ADDR_W    = 13,
    parameter int BANK_W    = 2,
    parameter int N_REFRESH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BANK_W-1:0] sd_ba,
    input logic              init_done,
    input logic              ref_en,
    input logic              ref_req
);
    logic [3:0]  cmd;
    logic        pre_seen;
    logic [15:0] ref_seen;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Track the precharge and count the refreshes seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_seen <= 1'b0;
            ref_seen <= '0;
        end else begin
            if (cmd == 4'b0010) pre_seen <= 1'b1;
            if (cmd == 4'b0001) ref_seen <= ref_seen + 1'b1;
        end
    end

    // R4
    pre_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> !pre_seen);
    // R4
    pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> (sd_addr == (ADDR_W'(1) << 10)) && (sd_ba == '0));
    // R5
    ref_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0001) |-> pre_seen);
    // R5
    ref_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (ref_seen == 16'(N_REFRESH)));
    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    // R8
    run_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == 4'b0111));
    // R9
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |-> !ref_req);
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .N_REFRESH(N_REFRESH)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba),
    .init_done(init_done), .ref_en(ref_en), .ref_req(ref_req)
);

// File: tb/tb_sdram_boot_seq.sv
module tb_sdram_boot_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;
    localparam int WAIT_CYC = 5;
    localparam int T_RP = 2;
    localparam int T_RFC = 3;
    localparam int T_MRD = 2;
    localparam int N_REF = 8;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [15:0] gap;
        logic [15:0] reps;
    } seg_t;

    // Bring-up trace after the power-up wait: command, recovery NOPs, repeats.
    localparam seg_t SEQ [3] = '{
        '{4'b0010, 16'(T_RP),  16'd1},
        '{4'b0001, 16'(T_RFC), 16'(N_REF)},
        '{4'b0000, 16'(T_MRD), 16'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_mode_word = '0;
    logic [BANK_W-1:0] cfg_mode_bank = '0;
    logic [7:0]  cfg_ref_prescale = '0;
    logic [15:0] cfg_ref_period = 16'd1;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [BANK_W-1:0] sd_ba;
    logic init_done, ref_en, ref_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_boot_seq #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PRE_W(8), .PER_W(16),
        .WAIT_CYC(WAIT_CYC), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
        .N_REFRESH(N_REF)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode_word(cfg_mode_word), .cfg_mode_bank(cfg_mode_bank),
        .cfg_ref_prescale(cfg_ref_prescale), .cfg_ref_period(cfg_ref_period),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba),
        .init_done(init_done), .ref_en(ref_en), .ref_req(ref_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0010: return "R4";
            4'b0001: return "R5";
            4'b0000: return "R2/R6";
            default: return "R8";
        endcase
    endfunction

    // One sequence cycle: command pins, address, bank, flags all low.
    task automatic seq_cycle(input logic [3:0] ec, input logic [ADDR_W-1:0] ea,
                             input logic [BANK_W-1:0] eb, input string tag);
        logic [3:0] c;
        @(negedge clk);
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(c == ec, tag, 32'(c), 32'(ec));
        chk(sd_addr == ea, tag, 32'(sd_addr), 32'(ea));
        chk(sd_ba == eb, tag, 32'(sd_ba), 32'(eb));
        chk(!init_done && !ref_en, "R7", 32'({init_done, ref_en}), 32'd0);
        chk(!ref_req, "R9", 32'(ref_req), 32'd0);
    endtask

    // Walk the full bring-up trace; first call samples the clock after capture.
    task automatic run_sequence(input logic [ADDR_W-1:0] mode, input logic [BANK_W-1:0] bank);
        logic [ADDR_W-1:0] ea;
        logic [BANK_W-1:0] eb;
        logic [3:0] c;
        for (int i = 0; i < WAIT_CYC; i++) seq_cycle(4'b0111, '0, '0, "R3");
        for (int s = 0; s < 3; s++) begin
            for (int r = 0; r < int'(SEQ[s].reps); r++) begin
                ea = '0; eb = '0;
                if (SEQ[s].cmd == 4'b0010) ea = ADDR_W'(1) << 10;
                if (SEQ[s].cmd == 4'b0000) begin ea = mode; eb = bank; end
                seq_cycle(SEQ[s].cmd, ea, eb, tag_of(SEQ[s].cmd));
                for (int g = 0; g < int'(SEQ[s].gap); g++)
                    seq_cycle(4'b0111, '0, '0, tag_of(SEQ[s].cmd));
            end
        end
        @(negedge clk);
        chk(init_done && ref_en, "R7", 32'({init_done, ref_en}), 32'd3);
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(c == 4'b0111, "R8", 32'(c), 32'h7);
        chk(!ref_req, "R9", 32'(ref_req), 32'd0);
    endtask

    // Refresh request pattern after init_done rose (k counted from that cycle).
    task automatic check_refresh(input int interval, input int ncyc);
        logic [3:0] c;
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            chk(ref_req == ((k % interval) == 0), "R2/R9", 32'(ref_req),
                32'((k % interval) == 0));
            chk(init_done && ref_en, "R7", 32'({init_done, ref_en}), 32'd3);
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            chk(c == 4'b0111 && sd_addr == '0 && sd_ba == '0, "R8", 32'(c), 32'h7);
        end
    endtask

    task automatic check_reset_state(input string tag);
        logic [3:0] c;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(c == 4'b0111, tag, 32'(c), 32'h7);
        chk(!init_done && !ref_en && !ref_req, tag,
            32'({init_done, ref_en, ref_req}), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Run 1: prescale 1, period 3 -> interval 6.
        cfg_mode_word = 13'h0232; cfg_mode_bank = 2'b00;
        cfg_ref_prescale = 8'd1; cfg_ref_period = 16'd3;
        repeat (3) @(negedge clk);
        check_reset_state("R1");
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_reset_state("R1");
        // R2: values changed after the capture clock must be ignored.
        cfg_mode_word = 13'h1FFF; cfg_mode_bank = 2'b11;
        cfg_ref_prescale = 8'd0; cfg_ref_period = 16'd2;
        run_sequence(13'h0232, 2'b00);
        check_refresh(6, 20);

        // R10: reset during run, then reset again mid-sequence.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R10");
        rst_n = 1'b1;
        repeat (14) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R10");
        // Run 2: prescale 0, period 4 -> interval 4.
        cfg_mode_word = 13'h0027; cfg_mode_bank = 2'b01;
        cfg_ref_prescale = 8'd0; cfg_ref_period = 16'd4;
        rst_n = 1'b1;
        run_sequence(13'h0027, 2'b01);
        check_refresh(4, 12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule